// File: doc/BRIEF.md
# External Bus Transaction Sequencer

This block runs one external bus transaction at a time. A requester offers a transfer: a memory or I/O space flag, a read or write flag, an address and, for a write, a data word. The sequencer takes it through a fixed series of clock states. In the first state it strobes the address latch enable and drives the address. In the second state it raises the read or write command and the data buffer enable. For a write it also drives the data word. It then stretches the transfer with wait states for as long as the slave holds its ready input low. In the third state it captures the read data. In the fourth state it drops every command and reports completion with a one-clock done pulse.

When nothing is requested, the sequencer sits in idle states of one clock each. A new request is taken only in idle or in the completing fourth state. Taking it in the fourth state lets transfers run back to back with no idle clock between them. A transfer always lasts four clocks plus one clock for each wait state.

Top module: `busCycleSeq`

## Requirements
- R1: While reset is held, and right after it is released, the sequencer is idle. In this state busAle, busAddrOe, busRd, busWr, busDen, busDataOe, rspDone, busIoM and busDtR are all 0 and reqReady is 1. A request presented during reset starts nothing.
- R2: A request accepted on a clock edge starts the address state in the next clock. In that state busAle and busAddrOe are 1 and busAddr equals the request address. busAle is 1 for that one clock only. Outside the address state busAddrOe is 0 and busAddr is 0.
- R3: From the second state through the third state, including every wait state, busDen is 1. busRd is 1 for a read and busWr is 1 for a write. For a write, busDataOe is 1 and busDataOut carries the request data. For a read, busDataOe stays 0. busRd and busWr are never 1 together.
- R4: ready is sampled on the edge that ends the second state and on the edge that ends each wait state. Each such sample that is 0 adds one wait state. The first sample that is 1 moves to the third state. ready has no effect in any other state.
- R5: busDataIn is captured on the edge that ends the third state. The captured value appears on rspData during the done clock. The bus value in any other clock is not captured.
- R6: In the fourth state, busRd, busWr, busDen and busDataOe are 0 and rspDone is 1. rspDone is 1 for exactly one clock per transfer.
- R7: With N wait states, the fourth state is the (4+N)th clock after the clock in which busAle rose, counting the busAle clock as the first.
- R8: reqReady is 1 only in idle and in the fourth state. A request seen in the fourth state goes straight into the address state with no idle clock. With no request, each idle clock keeps every bus control at 0.
- R9: busIoM is 1 for an I/O space transfer and 0 for a memory space transfer. busDtR is 1 for a write (transmit) and 0 for a read (receive). Both keep their values from the address state through the fourth state and are 0 in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Transfer request present |
| reqIsIo | input | 1 | 1 = I/O space, 0 = memory space |
| reqIsWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (20) | Transfer address |
| reqWdata | input | DATA_W (16) | Write data |
| reqReady | output | 1 | Request accepted on this edge if reqValid |
| ready | input | 1 | Slave ready, low inserts wait states |
| busDataIn | input | DATA_W (16) | Data returned by the slave |
| busAle | output | 1 | Address latch enable |
| busAddrOe | output | 1 | Address drive enable on the shared bus |
| busAddr | output | ADDR_W (20) | Address driven during the address state |
| busIoM | output | 1 | Space select, 1 = I/O |
| busDtR | output | 1 | Direction, 1 = transmit |
| busDen | output | 1 | Data buffer enable |
| busRd | output | 1 | Read command |
| busWr | output | 1 | Write command |
| busDataOe | output | 1 | Write data drive enable |
| busDataOut | output | DATA_W (16) | Write data |
| rspData | output | DATA_W (16) | Captured read data |
| rspDone | output | 1 | One-clock completion pulse |

## Verification
The bench sweeps every mix of space and direction with zero to four wait states and idle gaps of zero to two clocks. The zero gap case covers back-to-back requests taken in the fourth state. A sequencer that samples ready in the wrong state, or that forgets to sample it again in a wait state, gives a done pulse in the wrong clock. A sequencer that stalls on ready in the third state does the same. The bench holds ready low in the third state to catch that stall. It also drives a decoy value on the data bus in every clock except the third state, so a capture one clock early or late returns the wrong read data. A request in the fourth state must reach the address state with no idle clock in between. Command or enable signals that last into the fourth state, or a done pulse longer than one clock, fail the per-clock checks.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_CMD  = 3'd2,
    ST_WAIT = 3'd3,
    ST_XFER = 3'd4,
    ST_END  = 3'd5
  } busState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new request
    logic aleOn;    // address latch enable
    logic addrOn;   // drive address
    logic cmdOn;    // read or write command
    logic denOn;    // data buffer enable
    logic capture;  // capture read data on this edge
    logic done;     // completion clock
    logic active;   // any state of a transfer
  } seqStrobe_t;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       ready,
  output logic       reqReady,
  output seqStrobe_t strobe
);

  busState_e stateQ;
  busState_e stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (reqValid) stateD = ST_ADDR;
      ST_ADDR: stateD = ST_CMD;
      ST_CMD:  stateD = ready ? ST_XFER : ST_WAIT;
      ST_WAIT: stateD = ready ? ST_XFER : ST_WAIT;
      ST_XFER: stateD = ST_END;
      ST_END:  stateD = reqValid ? ST_ADDR : ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  logic inCmdWindow;
  assign inCmdWindow = (stateQ == ST_CMD) || (stateQ == ST_WAIT) ||
                       (stateQ == ST_XFER);
  assign reqReady    = (stateQ == ST_IDLE) || (stateQ == ST_END);

  always_comb begin
    strobe         = '0;
    strobe.load    = reqReady && reqValid;
    strobe.aleOn   = (stateQ == ST_ADDR);
    strobe.addrOn  = (stateQ == ST_ADDR);
    strobe.cmdOn   = inCmdWindow;
    strobe.denOn   = inCmdWindow;
    strobe.capture = (stateQ == ST_XFER);
    strobe.done    = (stateQ == ST_END);
    strobe.active  = (stateQ != ST_IDLE);
  end

endmodule

// File: rtl/busSeqDatapath.sv
module busSeqDatapath
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              reqIsIo,
  input  logic              reqIsWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              busAle,
  output logic              busAddrOe,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busIoM,
  output logic              busDtR,
  output logic              busDen,
  output logic              busRd,
  output logic              busWr,
  output logic              busDataOe,
  output logic [DATA_W-1:0] busDataOut,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              isIoQ;
  logic              isWrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      isIoQ  <= 1'b0;
      isWrQ  <= 1'b0;
    end else if (strobe.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      isIoQ  <= reqIsIo;
      isWrQ  <= reqIsWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rdataQ <= '0;
    else if (strobe.capture) rdataQ <= busDataIn;
  end

  assign busAle     = strobe.aleOn;
  assign busAddrOe  = strobe.addrOn;
  assign busAddr    = strobe.addrOn ? addrQ : '0;
  assign busIoM     = strobe.active && isIoQ;
  assign busDtR     = strobe.active && isWrQ;
  assign busDen     = strobe.denOn;
  assign busRd      = strobe.cmdOn && !isWrQ;
  assign busWr      = strobe.cmdOn && isWrQ;
  assign busDataOe  = strobe.denOn && isWrQ;
  assign busDataOut = busDataOe ? wdataQ : '0;
  assign rspData    = rdataQ;
  assign rspDone    = strobe.done;

endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsIo,
  input  logic              reqIsWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  input  logic              ready,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              busAle,
  output logic              busAddrOe,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busIoM,
  output logic              busDtR,
  output logic              busDen,
  output logic              busRd,
  output logic              busWr,
  output logic              busDataOe,
  output logic [DATA_W-1:0] busDataOut,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone
);

  seqStrobe_t strobe;

  busSeqCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .ready    (ready),
    .reqReady (reqReady),
    .strobe   (strobe)
  );

  busSeqDatapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqIsIo    (reqIsIo),
    .reqIsWrite (reqIsWrite),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .busDataIn  (busDataIn),
    .busAle     (busAle),
    .busAddrOe  (busAddrOe),
    .busAddr    (busAddr),
    .busIoM     (busIoM),
    .busDtR     (busDtR),
    .busDen     (busDen),
    .busRd      (busRd),
    .busWr      (busWr),
    .busDataOe  (busDataOe),
    .busDataOut (busDataOut),
    .rspData    (rspData),
    .rspDone    (rspDone)
  );

endmodule

// File: rtl/busCycleSeqChecker.sv
module busCycleSeqChecker (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic busAle,
  input logic busIoM,
  input logic busDtR,
  input logic busDen,
  input logic busRd,
  input logic busWr,
  input logic busDataOe,
  input logic rspDone
);

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    busAle |=> !busAle);

  p_ale_then_cmd_r2: assert property (@(posedge clk) disable iff (!rstN)
    busAle |=> (busRd || busWr));

  p_cmd_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  p_cmd_has_den_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |-> busDen);

  p_oe_only_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> busWr);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (!busRd && !busWr && !busDen && !busDataOe));

  p_accept_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!busAle && !busRd && !busWr));

  p_type_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |=> ($stable(busIoM) && $stable(busDtR)));

endmodule

bind busCycleSeq busCycleSeqChecker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .busAle    (busAle),
  .busIoM    (busIoM),
  .busDtR    (busDtR),
  .busDen    (busDen),
  .busRd     (busRd),
  .busWr     (busWr),
  .busDataOe (busDataOe),
  .rspDone   (rspDone)
);

// File: tb/tb_busCycleSeq.sv
`timescale 1ns/100ps
module tb_busCycleSeq;

  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN;
  logic          reqValid;
  logic          reqIsIo;
  logic          reqIsWrite;
  logic [AW-1:0] reqAddr;
  logic [DW-1:0] reqWdata;
  logic          reqReady;
  logic          ready;
  logic [DW-1:0] busDataIn;
  logic          busAle, busAddrOe, busIoM, busDtR, busDen, busRd, busWr;
  logic          busDataOe, rspDone;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busDataOut, rspData;

  int vecCount  = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  busCycleSeq dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsIo(reqIsIo),
    .reqIsWrite(reqIsWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqReady(reqReady), .ready(ready), .busDataIn(busDataIn),
    .busAle(busAle), .busAddrOe(busAddrOe), .busAddr(busAddr),
    .busIoM(busIoM), .busDtR(busDtR), .busDen(busDen), .busRd(busRd),
    .busWr(busWr), .busDataOe(busDataOe), .busDataOut(busDataOut),
    .rspData(rspData), .rspDone(rspDone)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string req, input string what);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chkIdle(input string req);
    chk(busAle,    0, req, "idle busAle");
    chk(busAddrOe, 0, req, "idle busAddrOe");
    chk(busRd,     0, req, "idle busRd");
    chk(busWr,     0, req, "idle busWr");
    chk(busDen,    0, req, "idle busDen");
    chk(busDataOe, 0, req, "idle busDataOe");
    chk(rspDone,   0, req, "idle rspDone");
    chk(busIoM,    0, req, "idle busIoM");
    chk(busDtR,    0, req, "idle busDtR");
    chk(reqReady,  1, req, "idle reqReady");
  endtask

  // Entered at a negedge in idle or the end state; returns at the
  // negedge of this transfer's end state.
  task automatic runTxn(input bit isIo, input bit isWr,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic [DW-1:0] rdv, input int w, input int gap);
    reqValid = 1'b0;
    for (int g = 0; g < gap; g++) begin
      @(posedge clk); @(negedge clk);
      chkIdle("R8");
    end
    reqValid   = 1'b1;
    reqIsIo    = isIo;
    reqIsWrite = isWr;
    reqAddr    = a;
    reqWdata   = wd;
    chk(reqReady, 1, "R8", "ready to accept");
    for (int c = 1; c <= 4 + w; c++) begin
      @(posedge clk); @(negedge clk);
      if (c == 1) reqValid = 1'b0;
      chk(busIoM, isIo, "R9", "space select");
      chk(busDtR, isWr, "R9", "direction");
      if (c == 1) begin
        chk(busAle,    1, "R2", "ale in address state");
        chk(busAddrOe, 1, "R2", "address enable");
        chk(busAddr,   a, "R2", "address value");
        chk(busRd | busWr | busDen, 0, "R3", "no command in address state");
        chk(rspDone,   0, "R6", "done low in address state");
        chk(reqReady,  0, "R8", "busy in address state");
      end else if (c < 4 + w) begin
        chk(busAle,    0, "R2", "ale single clock");
        chk(busAddr,   0, "R2", "address released");
        chk(busDen,    1, "R3", "den in command window");
        chk(busRd,     !isWr, "R3", "read command");
        chk(busWr,     isWr,  "R3", "write command");
        chk(busDataOe, isWr,  "R3", "write data enable");
        if (isWr) chk(busDataOut, wd, "R3", "write data");
        chk(rspDone,   0, "R7", "done not early");
        chk(reqReady,  0, "R8", "busy in command window");
      end else begin
        chk(rspDone,   1, "R7", "done at 4+N");
        chk(busRd | busWr | busDen | busDataOe, 0, "R6", "end state quiet");
        chk(reqReady,  1, "R8", "accept in end state");
        if (!isWr) chk(rspData, rdv, "R5", "read data");
      end
      // ready: meaningful at end of T2 and each TW, low elsewhere (R4)
      if (c >= 2 && c <= 2 + w) ready = (c == 2 + w);
      else                      ready = 1'b0;
      busDataIn = (c == 3 + w) ? rdv : ~rdv;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin : stim
    int idx;
    rstN = 1'b0; reqValid = 1'b1; reqIsIo = 1'b1; reqIsWrite = 1'b1;
    reqAddr = '1; reqWdata = '1; ready = 1'b1; busDataIn = '0;
    repeat (3) @(negedge clk);
    chkIdle("R1");
    reqValid = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1");
    idx = 0;
    for (int io = 0; io < 2; io++)
      for (int wr = 0; wr < 2; wr++)
        for (int w = 0; w <= 4; w++)
          for (int gap = 0; gap <= 2; gap++) begin
            idx++;
            runTxn(io[0], wr[0],
                   AW'((idx * 32'h1357 + 32'h0A5A5) & 32'hFFFFF),
                   DW'(idx * 16'h0F1D + 16'h1234),
                   DW'(idx * 16'h2B3 ^ 16'hC3A5), w, gap);
          end
    reqValid = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(rspDone, 0, "R6", "done one clock");
    chkIdle("R8");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

endmodule